// File: doc/BRIEF.md
# USB Endpoint Buffer Descriptor Engine

This block holds the buffer descriptors of every physical endpoint of a USB device controller and acts on the simplified token events that a packet engine hands it. Each physical endpoint owns two 32-bit descriptor words, one per buffer. For every token the engine looks up the selected descriptor and answers with a handshake decision: acknowledge, NAK, stall, or no answer at all. On an acknowledged packet it rewrites the descriptor in place. The remaining byte count drops by the packet size and the buffer address offset, kept in 64-byte units, advances by the packet size divided by 64. The active flag drops when the buffer is finished, and the per-endpoint data toggle moves on. A finished buffer raises that endpoint's interrupt bit.

Software owns the descriptors through a word-wide read/write port. It can deactivate buffers through a write-one skip strobe, enable double buffering per endpoint, and set or observe the per-endpoint in-use bits that pick which buffer is live. The physical endpoint index is twice the logical endpoint number, plus one for the IN direction. Data movement, CRC and line coding belong to other blocks.

A two-state machine runs each token. In S_IDLE the block shows `tok_ready` and waits. The transition "accept" (S_IDLE to S_EXEC, taken when `tok_valid` is high) captures the token. The transition "commit" (S_EXEC to S_IDLE, always taken) writes the descriptor, toggle, in-use and interrupt updates. On that same edge it registers the response, so `rsp_valid` is high for exactly the one cycle after commit.

Top module: `ebd_engine`

## Requirements
- R1: After reset, descriptors of physical endpoints 0 and 1 read 0x00000000 and all others read 0x40000000 (disable bit 30 set). The in-use bits and interrupt bits are zero, `rsp_valid` is 0 and `tok_ready` is 1.
- R2: A token gets code NONE (0) and changes nothing in these cases: its endpoint number is not below NUM_LOG_EP, the selected descriptor has disable (bit 30) set, its kind is SETUP on an endpoint other than 0, or its kind is the unused value 3. Token kinds are OUT=0, IN=1 and SETUP=2.
- R3: The response comes in the cycle after the commit edge, one cycle after acceptance. For an active descriptor (bit 31) the code is ACK (1), and the response carries the packet size. That size is min(count, MAX_PKT) for IN, and the OUT token byte count limited to count for OUT. The count field [25:16] drops by the size and the offset [15:0] grows by size/64.
- R4: The active bit clears when the packet is short or the count reaches zero. An IN packet is short when its size is below MAX_PKT; an OUT packet is short when the token says so. This clearing sets the endpoint's interrupt bit.
- R5: A STALL (3) is returned only when active is 0 and stall (bit 29) is 1. An active descriptor is ACKed regardless of stall. An enabled descriptor that is neither active nor stalled gets NAK (2). Non-ACK responses carry size 0.
- R6: A skip strobe clears the active bit of both buffers of every masked endpoint and sets no interrupt bit.
- R7: A SETUP token on endpoint 0 whose descriptor is enabled is ACKed with toggle 0. It sets the data toggle of physical endpoints 0 and 1 to 1 and sets interrupt bit 0.
- R8: On ACK with toggle reset (bit 28) set, the packet uses the toggle value (bit 27) and bit 28 is cleared in the descriptor. Otherwise the packet uses the stored toggle. After each ACK the stored toggle becomes the inverse of the toggle used.
- R9: On a non-control, non-isochronous (bit 26 clear) endpoint with toggle reset 0 and toggle value 1, every packet uses toggle 0 and the stored toggle stays 0.
- R10: With double buffering enabled for an endpoint, the in-use bit selects the buffer (0 or 1). Each completed buffer flips that in-use bit, so the completed buffer is the one opposite the new in-use value.
- R11: Writing ones to `cfg_int_clr` clears the matching interrupt bits.
- R12: A token on logical endpoint n uses physical endpoint 2n for OUT/SETUP and 2n+1 for IN. Its interrupt is the bit of that physical index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Token event present |
| tok_ready | output | 1 | Engine idle, token accepted this cycle if valid |
| tok_ep | input | LOG_W | Logical endpoint number |
| tok_kind | input | 2 | 0 OUT, 1 IN, 2 SETUP |
| tok_bytes | input | PKT_W | OUT packet byte count |
| tok_short | input | 1 | OUT packet was short |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_code | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |
| rsp_toggle | output | 1 | Data toggle used by the packet |
| rsp_bytes | output | PKT_W | Packet size handled |
| cfg_desc_we | input | 1 | Descriptor word write strobe |
| cfg_desc_ep | input | PHY_W | Physical endpoint of the descriptor port |
| cfg_desc_buf | input | 1 | Buffer select of the descriptor port |
| cfg_desc_wdata | input | 32 | Descriptor write data |
| cfg_desc_rdata | output | 32 | Descriptor read data at the same address |
| cfg_skip_we | input | 1 | Skip strobe |
| cfg_skip_mask | input | NUM_PHY | Endpoints whose buffers are deactivated |
| cfg_inuse_we | input | 1 | In-use register write strobe |
| cfg_inuse_wdata | input | NUM_PHY | In-use write data |
| cfg_dbuf_we | input | 1 | Double-buffer enable write strobe |
| cfg_dbuf_wdata | input | NUM_PHY | Double-buffer enable write data |
| cfg_int_clr | input | NUM_PHY | Write-one-to-clear of interrupt bits |
| ep_inuse | output | NUM_PHY | In-use bits |
| ep_int | output | NUM_PHY | Endpoint interrupt bits |

## Verification
The assertions rely on software not writing the in-use register in the same cycle that a double-buffered completion commits. They also assume no descriptor or skip write goes to the endpoint whose token is in flight. The bench applies every configuration write only while `tok_ready` is high and no token is being driven. It waits for each response before touching configuration again. Tokens are sent only when the engine is idle, and OUT byte counts never exceed the descriptor's count.

// File: rtl/ebd_pkg.sv
package ebd_pkg;

    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_IN    = 2'd1,
        TK_SETUP = 2'd2,
        TK_RSVD  = 2'd3
    } tok_kind_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_EXEC = 1'b1
    } eng_state_e;

    // bit 31 down to bit 0
    typedef struct packed {
        logic        active;
        logic        dis;
        logic        stall;
        logic        tog_rst;
        logic        tog_val;
        logic        iso;
        logic [9:0]  count;
        logic [15:0] offset;
    } desc_t;

endpackage

// File: rtl/ebd_desc_store.sv
module ebd_desc_store #(
    parameter int NUM_PHY = 10,
    parameter int PHY_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHY_W:0]    eng_addr,
    output logic [31:0]       eng_rdata,
    input  logic              eng_we,
    input  logic [31:0]       eng_wdata,
    input  logic [PHY_W:0]    sw_addr,
    output logic [31:0]       sw_rdata,
    input  logic              sw_we,
    input  logic [31:0]       sw_wdata,
    input  logic              skip_we,
    input  logic [NUM_PHY-1:0] skip_mask
);
    localparam int NUM_WORDS = 2 * NUM_PHY;
    localparam int AW        = PHY_W + 1;

    logic [31:0] words   [NUM_WORDS];
    logic [31:0] words_n [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam logic [31:0] RST_VAL = ((w / 2) >= 2) ? 32'h4000_0000 : 32'h0;

        always_comb begin
            words_n[w] = words[w];
            if (eng_we && (eng_addr == AW'(w))) begin
                words_n[w] = eng_wdata;
            end else if (sw_we && (sw_addr == AW'(w))) begin
                words_n[w] = sw_wdata;
            end
            if (skip_we && skip_mask[w / 2]) begin
                words_n[w][31] = 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[w] <= RST_VAL;
            end else begin
                words[w] <= words_n[w];
            end
        end
    end

    assign eng_rdata = (32'(eng_addr) < NUM_WORDS) ? words[eng_addr] : 32'h0;
    assign sw_rdata  = (32'(sw_addr)  < NUM_WORDS) ? words[sw_addr]  : 32'h0;

endmodule

// File: rtl/ebd_toggle.sv
module ebd_toggle #(
    parameter int NUM_PHY = 10,
    parameter int PHY_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PHY_W-1:0] rd_idx,
    output logic             rd_val,
    input  logic             wr_en,
    input  logic [PHY_W-1:0] wr_idx,
    input  logic             wr_val,
    input  logic             setup_hit
);
    logic [NUM_PHY-1:0] tog;

    for (genvar g = 0; g < NUM_PHY; g++) begin : g_tog
        if (g < 2) begin : g_ctrl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tog[g] <= 1'b0;
                end else if (setup_hit) begin
                    tog[g] <= 1'b1;
                end else if (wr_en && (wr_idx == PHY_W'(g))) begin
                    tog[g] <= wr_val;
                end
            end
        end else begin : g_data
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tog[g] <= 1'b0;
                end else if (wr_en && (wr_idx == PHY_W'(g))) begin
                    tog[g] <= wr_val;
                end
            end
        end
    end

    assign rd_val = (32'(rd_idx) < NUM_PHY) ? tog[rd_idx] : 1'b0;

endmodule

// File: rtl/ebd_decide.sv
module ebd_decide
    import ebd_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int PKT_W   = 7
) (
    input  desc_t            cur,
    input  logic [1:0]       kind,
    input  logic             ep_ok,
    input  logic             is_ep0,
    input  logic             tog_cur,
    input  logic [PKT_W-1:0] out_bytes,
    input  logic             out_short,
    output logic [1:0]       hs,
    output desc_t            nxt,
    output logic             wb,
    output logic             done,
    output logic             tog_used,
    output logic             tog_we,
    output logic             tog_nxt,
    output logic [PKT_W-1:0] pkt_n,
    output logic             setup_hit
);
    localparam logic [9:0] MAXP = 10'(MAX_PKT);

    logic [9:0] n10;
    logic [9:0] rem;
    logic       shrt;
    logic       fb_mode;

    always_comb begin
        if (kind == TK_IN) begin
            n10  = (cur.count >= MAXP) ? MAXP : cur.count;
            shrt = (n10 < MAXP);
        end else begin
            n10  = (10'(out_bytes) > cur.count) ? cur.count : 10'(out_bytes);
            shrt = out_short;
        end
        rem     = cur.count - n10;
        fb_mode = !is_ep0 && !cur.iso && !cur.tog_rst && cur.tog_val;
    end

    always_comb begin
        hs        = HS_NONE;
        nxt       = cur;
        wb        = 1'b0;
        done      = 1'b0;
        tog_used  = 1'b0;
        tog_we    = 1'b0;
        tog_nxt   = tog_cur;
        pkt_n     = '0;
        setup_hit = 1'b0;
        if (ep_ok && !cur.dis) begin
            unique case (kind)
                TK_SETUP: begin
                    if (is_ep0) begin
                        hs        = HS_ACK;
                        done      = 1'b1;
                        setup_hit = 1'b1;
                    end
                end
                TK_OUT, TK_IN: begin
                    if (cur.active) begin
                        hs          = HS_ACK;
                        wb          = 1'b1;
                        pkt_n       = PKT_W'(n10);
                        nxt.count   = rem;
                        nxt.offset  = cur.offset + 16'(n10 >> 6);
                        nxt.tog_rst = 1'b0;
                        nxt.active  = !(shrt || (rem == 10'd0));
                        done        = shrt || (rem == 10'd0);
                        tog_we      = 1'b1;
                        if (fb_mode) begin
                            tog_used = 1'b0;
                            tog_nxt  = 1'b0;
                        end else begin
                            tog_used = cur.tog_rst ? cur.tog_val : tog_cur;
                            tog_nxt  = !(cur.tog_rst ? cur.tog_val : tog_cur);
                        end
                    end else if (cur.stall) begin
                        hs = HS_STALL;
                    end else begin
                        hs = HS_NAK;
                    end
                end
                default: hs = HS_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ebd_engine.sv
module ebd_engine
    import ebd_pkg::*;
#(
    parameter int NUM_LOG_EP = 5,
    parameter int MAX_PKT    = 64,
    parameter int LOG_W      = $clog2(NUM_LOG_EP),
    parameter int PHY_W      = LOG_W + 1,
    parameter int NUM_PHY    = 2 * NUM_LOG_EP,
    parameter int PKT_W      = $clog2(MAX_PKT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tok_valid,
    output logic               tok_ready,
    input  logic [LOG_W-1:0]   tok_ep,
    input  logic [1:0]         tok_kind,
    input  logic [PKT_W-1:0]   tok_bytes,
    input  logic               tok_short,
    output logic               rsp_valid,
    output logic [1:0]         rsp_code,
    output logic               rsp_toggle,
    output logic [PKT_W-1:0]   rsp_bytes,
    input  logic               cfg_desc_we,
    input  logic [PHY_W-1:0]   cfg_desc_ep,
    input  logic               cfg_desc_buf,
    input  logic [31:0]        cfg_desc_wdata,
    output logic [31:0]        cfg_desc_rdata,
    input  logic               cfg_skip_we,
    input  logic [NUM_PHY-1:0] cfg_skip_mask,
    input  logic               cfg_inuse_we,
    input  logic [NUM_PHY-1:0] cfg_inuse_wdata,
    input  logic               cfg_dbuf_we,
    input  logic [NUM_PHY-1:0] cfg_dbuf_wdata,
    input  logic [NUM_PHY-1:0] cfg_int_clr,
    output logic [NUM_PHY-1:0] ep_inuse,
    output logic [NUM_PHY-1:0] ep_int
);
    eng_state_e state, state_n;

    logic [LOG_W-1:0]   cap_ep;
    logic [1:0]         cap_kind;
    logic [PKT_W-1:0]   cap_bytes;
    logic               cap_short;
    logic [PHY_W-1:0]   cap_phys;
    logic               ep_ok;
    logic               is_ep0;
    logic               sel_buf;
    logic [NUM_PHY-1:0] dbuf_q;
    logic [NUM_PHY-1:0] phys_onehot;
    logic               commit;

    desc_t              cur_desc, nxt_desc;
    logic [31:0]        eng_rdata;
    logic [1:0]         hs;
    logic               wb, done, tog_used, tog_we, tog_nxt, setup_hit, tog_cur;
    logic [PKT_W-1:0]   pkt_n;
    logic [NUM_PHY-1:0] inuse_n, int_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: if (tok_valid) state_n = S_EXEC;
            S_EXEC: state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    assign tok_ready = (state == S_IDLE);
    assign commit    = (state == S_EXEC);

    // token capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_ep    <= '0;
            cap_kind  <= 2'd0;
            cap_bytes <= '0;
            cap_short <= 1'b0;
        end else if (tok_ready && tok_valid) begin
            cap_ep    <= tok_ep;
            cap_kind  <= tok_kind;
            cap_bytes <= tok_bytes;
            cap_short <= tok_short;
        end
    end

    assign cap_phys    = {cap_ep, (cap_kind == TK_IN)};
    assign ep_ok       = (32'(cap_ep) < NUM_LOG_EP);
    assign is_ep0      = (cap_ep == '0);
    assign sel_buf     = ep_ok ? (dbuf_q[cap_phys] & ep_inuse[cap_phys]) : 1'b0;
    assign phys_onehot = NUM_PHY'(1) << cap_phys;
    assign cur_desc    = desc_t'(eng_rdata);

    ebd_desc_store #(.NUM_PHY(NUM_PHY), .PHY_W(PHY_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .eng_addr  ({cap_phys, sel_buf}),
        .eng_rdata (eng_rdata),
        .eng_we    (commit && wb),
        .eng_wdata (nxt_desc),
        .sw_addr   ({cfg_desc_ep, cfg_desc_buf}),
        .sw_rdata  (cfg_desc_rdata),
        .sw_we     (cfg_desc_we),
        .sw_wdata  (cfg_desc_wdata),
        .skip_we   (cfg_skip_we),
        .skip_mask (cfg_skip_mask)
    );

    ebd_toggle #(.NUM_PHY(NUM_PHY), .PHY_W(PHY_W)) u_tog (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (cap_phys),
        .rd_val    (tog_cur),
        .wr_en     (commit && tog_we),
        .wr_idx    (cap_phys),
        .wr_val    (tog_nxt),
        .setup_hit (commit && setup_hit)
    );

    ebd_decide #(.MAX_PKT(MAX_PKT), .PKT_W(PKT_W)) u_dec (
        .cur       (cur_desc),
        .kind      (cap_kind),
        .ep_ok     (ep_ok),
        .is_ep0    (is_ep0),
        .tog_cur   (tog_cur),
        .out_bytes (cap_bytes),
        .out_short (cap_short),
        .hs        (hs),
        .nxt       (nxt_desc),
        .wb        (wb),
        .done      (done),
        .tog_used  (tog_used),
        .tog_we    (tog_we),
        .tog_nxt   (tog_nxt),
        .pkt_n     (pkt_n),
        .setup_hit (setup_hit)
    );

    always_comb begin
        inuse_n = cfg_inuse_we ? cfg_inuse_wdata : ep_inuse;
        if (commit && done && !setup_hit && dbuf_q[cap_phys]) begin
            inuse_n = (cfg_inuse_we ? ep_inuse : inuse_n) ^ phys_onehot;
        end
        int_n = ep_int & ~cfg_int_clr;
        if (commit && done) begin
            int_n = int_n | phys_onehot;
        end
    end

    // outputs and endpoint registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_code   <= HS_NONE;
            rsp_toggle <= 1'b0;
            rsp_bytes  <= '0;
            ep_inuse   <= '0;
            ep_int     <= '0;
            dbuf_q     <= '0;
        end else begin
            rsp_valid <= commit;
            if (commit) begin
                rsp_code   <= hs;
                rsp_toggle <= tog_used;
                rsp_bytes  <= pkt_n;
            end
            ep_inuse <= inuse_n;
            ep_int   <= int_n;
            if (cfg_dbuf_we) begin
                dbuf_q <= cfg_dbuf_wdata;
            end
        end
    end

endmodule

// File: rtl/ebd_engine_chk.sv
module ebd_engine_chk #(
    parameter int NUM_PHY = 10,
    parameter int PKT_W   = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tok_valid,
    input logic               tok_ready,
    input logic               rsp_valid,
    input logic [1:0]         rsp_code,
    input logic [PKT_W-1:0]   rsp_bytes,
    input logic               cfg_inuse_we,
    input logic [NUM_PHY-1:0] ep_inuse,
    input logic [NUM_PHY-1:0] ep_int
);
    // R3
    resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_ready) |-> ##2 rsp_valid);

    // R3
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_ready) |=> !tok_ready);

    // R3
    single_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4
    int_from_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ep_int & ~$past(ep_int))) |-> (rsp_valid && rsp_code == 2'd1));

    // R5
    nonack_no_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 2'd1) |-> (rsp_bytes == '0));

    // R10
    inuse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_inuse != $past(ep_inuse)) |-> ($past(cfg_inuse_we) || (rsp_valid && rsp_code == 2'd1)));

endmodule

bind ebd_engine ebd_engine_chk #(.NUM_PHY(NUM_PHY), .PKT_W(PKT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tok_valid    (tok_valid),
    .tok_ready    (tok_ready),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code),
    .rsp_bytes    (rsp_bytes),
    .cfg_inuse_we (cfg_inuse_we),
    .ep_inuse     (ep_inuse),
    .ep_int       (ep_int)
);

// File: tb/sim_ebd_engine.sv
module sim_ebd_engine;
    localparam int NLE   = 5;
    localparam int NPH   = 10;
    localparam int LW    = 3;
    localparam int PW    = 4;
    localparam int KW    = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tok_valid = 1'b0;
    logic           tok_ready;
    logic [LW-1:0]  tok_ep = '0;
    logic [1:0]     tok_kind = 2'd0;
    logic [KW-1:0]  tok_bytes = '0;
    logic           tok_short = 1'b0;
    logic           rsp_valid;
    logic [1:0]     rsp_code;
    logic           rsp_toggle;
    logic [KW-1:0]  rsp_bytes;
    logic           cfg_desc_we = 1'b0;
    logic [PW-1:0]  cfg_desc_ep = '0;
    logic           cfg_desc_buf = 1'b0;
    logic [31:0]    cfg_desc_wdata = '0;
    logic [31:0]    cfg_desc_rdata;
    logic           cfg_skip_we = 1'b0;
    logic [NPH-1:0] cfg_skip_mask = '0;
    logic           cfg_inuse_we = 1'b0;
    logic [NPH-1:0] cfg_inuse_wdata = '0;
    logic           cfg_dbuf_we = 1'b0;
    logic [NPH-1:0] cfg_dbuf_wdata = '0;
    logic [NPH-1:0] cfg_int_clr = '0;
    logic [NPH-1:0] ep_inuse;
    logic [NPH-1:0] ep_int;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 1'b0;

    typedef struct {
        logic [1:0]    code;
        logic          tog;
        logic [KW-1:0] bytes;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    ebd_engine #(.NUM_LOG_EP(NLE), .MAX_PKT(64)) u0 (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
        .tok_ep(tok_ep), .tok_kind(tok_kind), .tok_bytes(tok_bytes), .tok_short(tok_short),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_toggle(rsp_toggle), .rsp_bytes(rsp_bytes),
        .cfg_desc_we(cfg_desc_we), .cfg_desc_ep(cfg_desc_ep), .cfg_desc_buf(cfg_desc_buf),
        .cfg_desc_wdata(cfg_desc_wdata), .cfg_desc_rdata(cfg_desc_rdata),
        .cfg_skip_we(cfg_skip_we), .cfg_skip_mask(cfg_skip_mask),
        .cfg_inuse_we(cfg_inuse_we), .cfg_inuse_wdata(cfg_inuse_wdata),
        .cfg_dbuf_we(cfg_dbuf_we), .cfg_dbuf_wdata(cfg_dbuf_wdata),
        .cfg_int_clr(cfg_int_clr), .ep_inuse(ep_inuse), .ep_int(ep_int)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a response appears
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R3 unexpected response", 32'(rsp_code), 32'hFFFF);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(rsp_code == e.code, {e.tag, " code"}, 32'(rsp_code), 32'(e.code));
                chk(rsp_toggle == e.tog, {e.tag, " toggle"}, 32'(rsp_toggle), 32'(e.tog));
                chk(rsp_bytes == e.bytes, {e.tag, " bytes"}, 32'(rsp_bytes), 32'(e.bytes));
            end
        end
    end

    task automatic send_tok(input int ep, input int kind, input int nb, input bit sh,
                            input int ec, input bit et, input int eb, input string tag);
        exp_t e;
        @(negedge clk);
        while (!tok_ready) @(negedge clk);
        e.code = 2'(ec); e.tog = et; e.bytes = KW'(eb); e.tag = tag;
        sb.push_back(e);
        tok_valid = 1'b1; tok_ep = LW'(ep); tok_kind = 2'(kind);
        tok_bytes = KW'(nb); tok_short = sh;
        @(negedge clk);
        tok_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr_desc(input int ep, input bit b, input logic [31:0] d);
        @(negedge clk);
        cfg_desc_we = 1'b1; cfg_desc_ep = PW'(ep); cfg_desc_buf = b; cfg_desc_wdata = d;
        @(negedge clk);
        cfg_desc_we = 1'b0;
    endtask

    task automatic chk_desc(input int ep, input bit b, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_desc_ep = PW'(ep); cfg_desc_buf = b;
        #1;
        chk(cfg_desc_rdata == exp, tag, cfg_desc_rdata, exp);
    endtask

    task automatic chk_int(input logic [NPH-1:0] exp, input string tag);
        @(negedge clk);
        chk(ep_int == exp, tag, 32'(ep_int), 32'(exp));
    endtask

    initial begin
        #(20 * 100000);
        if (!done_flag) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tok_ready == 1'b1, "R1 ready", 32'(tok_ready), 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
        chk(ep_int == '0, "R1 int", 32'(ep_int), 0);
        chk(ep_inuse == '0, "R1 inuse", 32'(ep_inuse), 0);
        chk_desc(0, 0, 32'h0, "R1 ctrl desc");
        chk_desc(2, 1, 32'h4000_0000, "R1 data desc disabled");

        // R5 NAK on enabled idle control OUT
        send_tok(0, 0, 8, 1'b0, 2, 1'b0, 0, "R5 nak ep0");
        // R2 disabled endpoint ignored, descriptor untouched
        send_tok(1, 1, 0, 1'b0, 0, 1'b0, 0, "R2 disabled");
        chk_desc(3, 0, 32'h4000_0000, "R2 disabled desc unchanged");

        // R3 R8 R12 ep1 IN = physical 3, toggle reset to 0
        wr_desc(3, 0, 32'h9064_0010);
        send_tok(1, 1, 0, 1'b0, 1, 1'b0, 64, "R3 R8 ep1 in first");
        chk_desc(3, 0, 32'h8024_0011, "R3 R8 desc after first");
        send_tok(1, 1, 0, 1'b0, 1, 1'b1, 36, "R4 R8 ep1 in last");
        chk_desc(3, 0, 32'h0000_0011, "R4 desc after last");
        chk_int(10'h008, "R4 R12 int bit3");
        send_tok(1, 1, 0, 1'b0, 2, 1'b0, 0, "R5 nak after done");

        // R5 active overrides stall, then stall
        wr_desc(3, 0, 32'hA00A_0000);
        send_tok(1, 1, 0, 1'b0, 1, 1'b0, 10, "R5 active over stall");
        chk_desc(3, 0, 32'h2000_0000, "R5 desc stalled idle");
        send_tok(1, 1, 0, 1'b0, 3, 1'b0, 0, "R5 stall");

        // R11 clear
        @(negedge clk); cfg_int_clr = 10'h008;
        @(negedge clk); cfg_int_clr = '0;
        chk_int(10'h000, "R11 int cleared");

        // R4 OUT short packet on ep2 OUT = physical 4
        wr_desc(4, 0, 32'h8080_0000);
        send_tok(2, 0, 64, 1'b0, 1, 1'b0, 64, "R3 ep2 out full");
        chk_desc(4, 0, 32'h8040_0001, "R3 out desc mid");
        send_tok(2, 0, 20, 1'b1, 1, 1'b1, 20, "R4 ep2 out short");
        chk_desc(4, 0, 32'h002C_0001, "R4 out desc short");
        chk_int(10'h010, "R4 R12 int bit4");

        // R6 skip both buffers of physical 6, no interrupt
        wr_desc(6, 0, 32'h8040_0000);
        wr_desc(6, 1, 32'h8040_0000);
        @(negedge clk); cfg_skip_we = 1'b1; cfg_skip_mask = 10'h040;
        @(negedge clk); cfg_skip_we = 1'b0; cfg_skip_mask = '0;
        chk_desc(6, 0, 32'h0040_0000, "R6 skip buf0");
        chk_desc(6, 1, 32'h0040_0000, "R6 skip buf1");
        chk_int(10'h010, "R6 no int on skip");
        send_tok(3, 0, 8, 1'b0, 2, 1'b0, 0, "R6 nak after skip");

        // R7 setup on ep0
        send_tok(0, 2, 8, 1'b0, 1, 1'b0, 0, "R7 setup ack");
        chk_int(10'h011, "R7 int bit0");
        wr_desc(1, 0, 32'h8008_0000);
        send_tok(0, 1, 0, 1'b0, 1, 1'b1, 8, "R7 ep0 in toggle1");
        chk_int(10'h013, "R7 R12 int bit1");
        wr_desc(0, 0, 32'h8008_0000);
        send_tok(0, 0, 8, 1'b1, 1, 1'b1, 8, "R7 ep0 out toggle1");
        send_tok(1, 2, 8, 1'b0, 0, 1'b0, 0, "R2 setup on ep1");
        send_tok(7, 1, 0, 1'b0, 0, 1'b0, 0, "R2 out of range ep");
        send_tok(0, 3, 0, 1'b0, 0, 1'b0, 0, "R2 reserved kind");

        // R9 rate feedback on ep2 IN = physical 5
        wr_desc(5, 0, 32'h8880_0000);
        send_tok(2, 1, 0, 1'b0, 1, 1'b0, 64, "R9 feedback first");
        send_tok(2, 1, 0, 1'b0, 1, 1'b0, 64, "R9 feedback second");
        chk_desc(5, 0, 32'h0800_0002, "R9 feedback desc");
        chk_int(10'h033, "R9 int bit5");

        // R10 double buffering on ep3 IN = physical 7
        @(negedge clk); cfg_dbuf_we = 1'b1; cfg_dbuf_wdata = 10'h080;
        @(negedge clk); cfg_dbuf_we = 1'b0;
        wr_desc(7, 0, 32'h8040_0000);
        wr_desc(7, 1, 32'h801E_0001);
        send_tok(3, 1, 0, 1'b0, 1, 1'b0, 64, "R10 buf0");
        @(negedge clk);
        chk(ep_inuse == 10'h080, "R10 inuse flipped to 1", 32'(ep_inuse), 32'h080);
        chk_desc(7, 0, 32'h0000_0001, "R10 buf0 done");
        chk_desc(7, 1, 32'h801E_0001, "R10 buf1 untouched");
        send_tok(3, 1, 0, 1'b0, 1, 1'b1, 30, "R10 buf1");
        @(negedge clk);
        chk(ep_inuse == 10'h000, "R10 inuse flipped to 0", 32'(ep_inuse), 0);
        chk_desc(7, 1, 32'h0000_0001, "R10 buf1 done");
        chk_int(10'h0B3, "R10 int bit7");

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R3 all responses seen", 32'(sb.size()), 0);
        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule